// File: doc/BRIEF.md
# Shortened Reed-Solomon Check-Byte Encoder

This block produces the two check bytes of a shortened Reed-Solomon code over GF(2^8). It serves a two-dimensional product code for optical-disc sectors: one dimension uses 24 message bytes per vector and the other uses 43. The second dimension's vectors already hold the first dimension's check bytes. A per-codeword mode input selects the length. Both lengths share one generator polynomial because shortening only treats the missing leading symbols as zero.

Message bytes arrive one per clock on a valid/ready stream. A start flag marks the first byte. When the last message byte of the selected length has been taken, the block stalls its input and presents the high check byte, then the low check byte, on two consecutive output beats. It marks the second beat as the end of the burst. If a start flag arrives in the middle of a codeword, the block drops that codeword, pulses an error flag and begins a new codeword at that byte.

Top module: `rs_parity_enc`

## Requirements
- R1: Field arithmetic uses the polynomial x^8+x^4+x^3+x^2+1 (low byte 0x1D). The check bytes are the remainder of m(x)·x^2 modulo g(x) = x^2 + 0x03·x + 0x02. The first message byte is the highest-degree coefficient of m(x).
- R2: With in_long low at the start byte, exactly 24 accepted bytes make a codeword, and the check bytes follow the 24th byte.
- R3: With in_long high at the start byte, exactly 43 accepted bytes make a codeword, and the check bytes follow the 43rd byte.
- R4: The first output beat carries the x^1 remainder coefficient with out_last low. The next beat carries the x^0 coefficient with out_last high. The syndromes of the full codeword at 0x01 and 0x02 are both zero.
- R5: out_valid is high only on the two check beats, which begin in the cycle after the last message byte is accepted. in_ready is low on both beats and high again in the cycle after the second beat.
- R6: A start byte accepted while a codeword is incomplete raises err_restart for the following cycle only. The check bytes that follow are those of the new codeword alone.
- R7: Bytes offered with in_sof low while no codeword is open are ignored. They produce no output and do not change the next codeword's check bytes.
- R8: in_long is sampled only with the start byte. Changes to it during the rest of the codeword have no effect on length or check bytes.
- R9: During and after reset, out_valid, out_last and err_restart are low and in_ready is high.
- R10: Cycles with in_valid low, whatever in_sof, in_long and in_data carry, do not alter the codeword in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Message byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_sof | input | 1 | Offered byte starts a codeword |
| in_long | input | 1 | Length select at start byte: 0 = 24 bytes, 1 = 43 bytes |
| in_data | input | 8 | Message byte |
| out_valid | output | 1 | Check byte present |
| out_data | output | 8 | Check byte, high coefficient first |
| out_last | output | 1 | Second check byte of the pair |
| err_restart | output | 1 | One-cycle pulse: incomplete codeword abandoned |

## Verification
A corrupt remainder register shows up in the check bytes on the cycle right after the final message byte. The bench compares each pair against values it solves from the two syndrome equations, so a single wrong bit in either register is caught on that codeword. An off-by-one in the byte counter moves the check beats by one cycle, or makes one extra byte enter the remainder. Both effects show at the next codeword end, and impulse sweeps over every message position expose positional errors. A stale length or a missed restart corrupts the check bytes of the very next codeword.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
    localparam int          SYM_W    = 8;
    localparam logic [7:0]  POLY_LOW = 8'h1D;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PAR_HI = 2'd2,
        ST_PAR_LO = 2'd3
    } enc_state_e;
endpackage

// File: rtl/rsp_gf_cmul.sv
// Multiply a field element by a constant; unrolled shift-and-add.
module rsp_gf_cmul #(
    parameter int               SYM_W    = 8,
    parameter logic [SYM_W-1:0] POLY_LOW = 8'h1D,
    parameter logic [SYM_W-1:0] COEF     = 8'h03
) (
    input  logic [SYM_W-1:0] a,
    output logic [SYM_W-1:0] y
);
    always_comb begin
        logic [SYM_W-1:0] pw;
        logic [SYM_W-1:0] acc;
        pw  = a;
        acc = '0;
        for (int i = 0; i < SYM_W; i++) begin
            if (COEF[i]) acc = acc ^ pw;
            pw = {pw[SYM_W-2:0], 1'b0} ^ ({SYM_W{pw[SYM_W-1]}} & POLY_LOW);
        end
        y = acc;
    end
endmodule

// File: rtl/rsp_lfsr.sv
// Two-register remainder divider for a degree-2 generator.
module rsp_lfsr #(
    parameter int               SYM_W    = 8,
    parameter logic [SYM_W-1:0] POLY_LOW = 8'h1D,
    parameter logic [SYM_W-1:0] G1       = 8'h03,
    parameter logic [SYM_W-1:0] G0       = 8'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] rem_hi,
    output logic [SYM_W-1:0] rem_lo
);
    typedef struct packed {
        logic [SYM_W-1:0] hi;
        logic [SYM_W-1:0] lo;
    } rem_t;

    rem_t             rem_d, rem_q;
    logic [SYM_W-1:0] fb, fb_g1, fb_g0;

    // a restart byte divides into an empty remainder
    assign fb = din ^ (restart ? '0 : rem_q.hi);

    rsp_gf_cmul #(.SYM_W(SYM_W), .POLY_LOW(POLY_LOW), .COEF(G1))
        i_mul_g1 (.a(fb), .y(fb_g1));
    rsp_gf_cmul #(.SYM_W(SYM_W), .POLY_LOW(POLY_LOW), .COEF(G0))
        i_mul_g0 (.a(fb), .y(fb_g0));

    always_comb begin
        rem_d = rem_q;
        if (step) begin
            rem_d.hi = (restart ? '0 : rem_q.lo) ^ fb_g1;
            rem_d.lo = fb_g0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign rem_hi = rem_q.hi;
    assign rem_lo = rem_q.lo;
endmodule

// File: rtl/rsp_ctrl.sv
// Codeword sequencer: byte count, length latch, check-beat timing.
module rsp_ctrl
    import rs_enc_pkg::*;
#(
    parameter int K_SHORT = 24,
    parameter int K_LONG  = 43
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_long,
    output logic in_ready,
    output logic step,
    output logic restart,
    output logic out_valid,
    output logic sel_lo,
    output logic out_last,
    output logic err
);
    localparam int K_MAX = (K_LONG > K_SHORT) ? K_LONG : K_SHORT;
    localparam int CNT_W = $clog2(K_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(K_SHORT - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(K_LONG - 1);

    typedef struct packed {
        enc_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             lng;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;
    logic [CNT_W-1:0] last_idx;

    assign in_ready = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_DATA);
    assign accept   = in_valid && in_ready;
    assign last_idx = ctl_q.lng ? LAST_LONG : LAST_SHORT;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        step      = 1'b0;
        restart   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept && in_sof) begin
                    step      = 1'b1;
                    restart   = 1'b1;
                    ctl_d.st  = ST_DATA;
                    ctl_d.cnt = CNT_W'(1);
                    ctl_d.lng = in_long;
                end
            end
            ST_DATA: begin
                if (accept) begin
                    step = 1'b1;
                    if (in_sof) begin
                        restart   = 1'b1;
                        ctl_d.err = 1'b1;
                        ctl_d.cnt = CNT_W'(1);
                        ctl_d.lng = in_long;
                    end else if (ctl_q.cnt == last_idx) begin
                        ctl_d.st  = ST_PAR_HI;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_PAR_HI: ctl_d.st = ST_PAR_LO;
            ST_PAR_LO: ctl_d.st = ST_IDLE;
            default:   ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, cnt: '0, lng: 1'b0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign out_valid = (ctl_q.st == ST_PAR_HI) || (ctl_q.st == ST_PAR_LO);
    assign sel_lo    = (ctl_q.st == ST_PAR_LO);
    assign out_last  = sel_lo;
    assign err       = ctl_q.err;
endmodule

// File: rtl/rs_parity_enc.sv
module rs_parity_enc #(
    parameter int         SYM_W    = 8,
    parameter logic [7:0] POLY_LOW = 8'h1D,
    parameter int         K_SHORT  = 24,
    parameter int         K_LONG   = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic             in_long,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last,
    output logic             err_restart
);
    // g(x) = (x + 1)(x + alpha): linear term 1 ^ alpha, constant alpha
    localparam logic [SYM_W-1:0] ALPHA = SYM_W'(2);
    localparam logic [SYM_W-1:0] G1    = ALPHA ^ SYM_W'(1);
    localparam logic [SYM_W-1:0] G0    = ALPHA;
    localparam logic [SYM_W-1:0] POLY  = POLY_LOW[SYM_W-1:0];

    logic             step, restart, sel_lo;
    logic [SYM_W-1:0] rem_hi, rem_lo;

    rsp_ctrl #(.K_SHORT(K_SHORT), .K_LONG(K_LONG)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_long  (in_long),
        .in_ready (in_ready),
        .step     (step),
        .restart  (restart),
        .out_valid(out_valid),
        .sel_lo   (sel_lo),
        .out_last (out_last),
        .err      (err_restart)
    );

    rsp_lfsr #(.SYM_W(SYM_W), .POLY_LOW(POLY), .G1(G1), .G0(G0)) i_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .restart(restart),
        .din    (in_data),
        .rem_hi (rem_hi),
        .rem_lo (rem_lo)
    );

    assign out_data = !out_valid ? '0 : (sel_lo ? rem_lo : rem_hi);
endmodule

// File: rtl/rs_parity_enc_chk.sv
module rs_parity_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_sof,
    input logic out_valid,
    input logic out_last,
    input logic err_restart
);
    p_stall_on_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_last));

    p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_burst_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && in_ready));

    p_check_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> $past(in_valid && in_ready));

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_restart |-> $past(in_valid && in_ready && in_sof));
endmodule

bind rs_parity_enc rs_parity_enc_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sof     (in_sof),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .err_restart(err_restart)
);

// File: tb/test_rs_parity_enc.sv
module test_rs_parity_enc;
    localparam int KS = 24;
    localparam int KL = 43;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_long = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_last, err_restart;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [7:0] msg [0:63];
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    rs_parity_enc i_rs_parity_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_long(in_long), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .err_restart(err_restart)
    );

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] ginv(input logic [7:0] a);
        for (int v = 1; v < 256; v++)
            if (gmul(a, 8'(v)) == 8'h01) return 8'(v);
        return 8'h00;
    endfunction

    function automatic logic [7:0] rnd();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends k bytes from msg; verifies the check-byte pair by solving the
    // two syndrome equations, and the restart pulse on the first bytes.
    task automatic send_cw(input bit lng, input bit flip, input int gap,
                           input bit exp_err, input string req);
        int k = lng ? KL : KS;
        logic [7:0] s1, h, a2, p_hi, p_lo, o_hi, o_lo;
        for (int i = 0; i < k; i++) begin
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b1; in_data = rnd(); in_long = ~lng;
            end
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_data = msg[i];
            in_long  = (flip && i > 0) ? ~lng : lng;
            @(posedge clk); #1;
            if (i < 2) check(err_restart == (exp_err && i == 0), "R6 err pulse",
                             int'(err_restart), int'(exp_err && i == 0));
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        s1 = 8'h00; h = 8'h00;
        for (int i = 0; i < k; i++) begin
            s1 ^= msg[i];
            h = gmul(h, 8'h02) ^ msg[i];
        end
        a2   = gmul(h, 8'h04);
        p_hi = gmul(s1 ^ a2, ginv(8'h03));
        p_lo = s1 ^ p_hi;
        check(out_valid && !out_last && !in_ready, {req, " R5 first beat"},
              {out_valid, out_last, in_ready}, 3'b100);
        o_hi = out_data;
        check(o_hi == p_hi, {req, " R1 high byte"}, o_hi, p_hi);
        @(negedge clk);
        check(out_valid && out_last && !in_ready, {req, " R4 second beat"},
              {out_valid, out_last, in_ready}, 3'b110);
        o_lo = out_data;
        check(o_lo == p_lo, {req, " R1 low byte"}, o_lo, p_lo);
        check((s1 ^ o_hi ^ o_lo) == 8'h00 &&
              (a2 ^ gmul(o_hi, 8'h02) ^ o_lo) == 8'h00,
              {req, " R4 syndromes"}, {o_hi, o_lo}, {p_hi, p_lo});
        @(negedge clk);
        check(!out_valid && in_ready, {req, " R5 idle after pair"},
              {out_valid, in_ready}, 2'b01);
    endtask

    task automatic fill_rand(input int k);
        for (int i = 0; i < k; i++) msg[i] = rnd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid && !out_last && !err_restart, "R9 in reset",
              {in_ready, out_valid, out_last, err_restart}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !out_last && !err_restart, "R9 after reset",
              {in_ready, out_valid, out_last, err_restart}, 4'b1000);

        // zero and all-ones messages
        for (int i = 0; i < 64; i++) msg[i] = 8'h00;
        send_cw(1'b0, 1'b0, 0, 1'b0, "R2 zeros");
        for (int i = 0; i < 64; i++) msg[i] = 8'hFF;
        send_cw(1'b1, 1'b0, 0, 1'b0, "R3 ones");

        // impulse sweep over every position in both lengths
        for (int m = 0; m < 2; m++) begin
            int k = (m == 1) ? KL : KS;
            for (int p = 0; p < k; p++) begin
                for (int i = 0; i < 64; i++) msg[i] = 8'h00;
                msg[p] = 8'((p * 37 + 1) | 1);
                send_cw(m[0], 1'b0, 0, 1'b0, (m == 1) ? "R3 impulse" : "R2 impulse");
            end
        end

        // random messages, with idle gaps that carry junk
        for (int n = 0; n < 30; n++) begin
            fill_rand(KL);
            send_cw(n[0], 1'b0, (n % 3 == 0) ? 0 : (n % 5) + 1, 1'b0,
                    (n % 3 == 0) ? "R1 random" : "R10 gaps");
        end

        // length select toggled mid-codeword
        for (int n = 0; n < 4; n++) begin
            fill_rand(KL);
            send_cw(n[0], 1'b1, 0, 1'b0, "R8 mode flip");
        end

        // idle bytes without start flag
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_data = rnd(); in_long = 1'b1;
            @(posedge clk); #1;
            check(!out_valid && in_ready && !err_restart, "R7 idle bytes ignored",
                  {out_valid, in_ready, err_restart}, 3'b010);
        end
        fill_rand(KS);
        send_cw(1'b0, 1'b0, 0, 1'b0, "R7 codeword after idle bytes");

        // restart in the middle of a codeword
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 5 + r * 11; i++) begin
                @(negedge clk);
                in_valid = 1'b1; in_sof = (i == 0); in_data = rnd(); in_long = 1'b1;
                @(posedge clk); #1;
            end
            fill_rand(KL);
            send_cw(r[0], 1'b0, 0, 1'b1, "R6 restart");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule